// File: doc/BRIEF.md
# Three-Phase Gate-Drive Protection Core

This block is the clocked decision logic that sits between a motor controller's six PWM commands and the gate drivers of a three-phase half bridge. For each phase it accepts a high-side and a low-side request. It turns on at most one switch of that phase, and only when every protection condition allows it. All inputs arrive asynchronously and pass through two-flop synchronizers. The PWM requests are then cleaned of short pulses by a minimum-width filter.

Several conditions force switches off:

- A global drive-enable input turns off all six outputs when it is low.
- An over-current comparator bit acts only after a blanking interval. A qualified trip turns all six outputs off and raises a fault flag. The flag is held for a fixed time after the over-current clears.
- Low-side supply undervoltage kills every output and raises the fault flag. It also re-arms a per-phase lockout. Each high side then stays off until its own low-side request has been seen, so the bootstrap capacitor gets charged first.
- A per-phase bootstrap undervoltage flag removes only that phase's high side.

Blanking, minimum pulse width and fault hold are parameters counted in clock cycles.

Top module: `tri_gate_guard`

## Requirements
- R1: For a phase with protections clear, a high request alone (high=1, low=0) drives only `gate_hi` of that phase. A low request alone drives only `gate_lo`. No request leaves both off.
- R2: When both requests of a phase are 1, both outputs of that phase are 0. `gate_hi[p]` and `gate_lo[p]` are never 1 together.
- R3: While `drv_enable` is 0 all six outputs are 0. Normal decoding resumes when it returns to 1.
- R4: An `oc_cmp` pulse shorter than `BLANK_CYC` synchronized cycles has no effect on the outputs or `fault`. One that lasts long enough turns all six outputs off and sets `fault` to 1.
- R5: While `vdd_uv` is 1, all six outputs are 0 and `fault` is 1.
- R6: `boot_uv[p]` at 1 forces `gate_hi[p]` to 0 and leaves every other output unchanged. `gate_hi[p]` resumes once the flag clears.
- R7: After reset, and after every `vdd_uv` episode, `gate_hi[p]` stays 0 until `pwm_lo[p]` has been accepted as 1 at least once.
- R8: After `oc_cmp` falls, `fault` stays 1 and the outputs stay off for `HOLD_CYC` cycles. Normal operation then resumes without any other action.
- R9: A high or low pulse on any PWM input that is shorter than `FILT_CYC` cycles does not reach the outputs.
- R10: During and just after reset, all six outputs and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | 3 | High-side requests, bit p = phase p |
| pwm_lo | input | 3 | Low-side requests, bit p = phase p |
| drv_enable | input | 1 | 1 enables the drivers, 0 shuts all off |
| oc_cmp | input | 1 | Over-current comparator output, 1 = over limit |
| vdd_uv | input | 1 | Low-side supply undervoltage, 1 = under |
| boot_uv | input | 3 | Per-phase bootstrap undervoltage, 1 = under |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault | output | 1 | 1 while undervoltage or an over-current trip/hold is active |

## Verification
A stuck or mis-advanced trip state shows at the ports as a `fault` that rises too early, too late or never, or that drops before the hold count ends. Each of these differs from the expected edge by at least one cycle within about `BLANK_CYC + HOLD_CYC` cycles of the comparator change. A lockout flag left armed or cleared wrongly shows up as a missing or premature `gate_hi` within a few cycles of the filter delay. A broken filter counter lets a short PWM pulse through to a gate output within `FILT_CYC` plus three cycles of the pulse.

// File: rtl/gg_pkg.sv
package gg_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    typedef enum logic [1:0] {
        TS_RUN  = 2'd0,
        TS_TRIP = 2'd1,
        TS_HOLD = 2'd2
    } trip_state_t;

    // Interlocked decode of one half bridge: a request with its partner also set is dropped.
    function automatic leg_t leg_decide(input leg_t req, input logic en);
        leg_t r;
        r.hi = en & req.hi & ~req.lo;
        r.lo = en & req.lo & ~req.hi;
        return r;
    endfunction

endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/gg_glitch_filter.sv
module gg_glitch_filter #(
    parameter int W        = 6,
    parameter int FILT_CYC = 100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt  <= '0;
                q[i] <= 1'b0;
            end else if (d[i] == q[i]) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                cnt  <= '0;
                q[i] <= d[i];
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gg_trip_ctrl.sv
module gg_trip_ctrl
    import gg_pkg::*;
#(
    parameter int BLANK_CYC = 35,
    parameter int HOLD_CYC  = 165000
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_s,
    input  logic uv_s,
    output logic kill,
    output logic fault
);
    localparam int BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
    localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [BW-1:0] BLAST = BW'(BLANK_CYC - 1);
    localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

    trip_state_t st;
    logic [BW-1:0] bcnt;
    logic [HW-1:0] hcnt;
    logic qual;

    assign qual = oc_s && (bcnt == BLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TS_RUN;
            bcnt <= '0;
            hcnt <= '0;
        end else begin
            if (!oc_s)     bcnt <= '0;
            else if (!qual) bcnt <= bcnt + 1'b1;

            case (st)
                TS_RUN:  if (qual) st <= TS_TRIP;
                TS_TRIP: if (!oc_s) begin
                    st   <= TS_HOLD;
                    hcnt <= '0;
                end
                TS_HOLD: begin
                    if (qual)              st <= TS_TRIP;
                    else if (hcnt == HLAST) st <= TS_RUN;
                    else                   hcnt <= hcnt + 1'b1;
                end
                default: st <= TS_RUN;
            endcase
        end
    end

    assign kill  = (st != TS_RUN) || uv_s;
    assign fault = kill;
endmodule

// File: rtl/gg_phase_leg.sv
module gg_phase_leg
    import gg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_hi,
    input  logic req_lo,
    input  logic enable,
    input  logic uv_s,
    input  logic bs_s,
    output logic gate_hi,
    output logic gate_lo,
    output logic lock_q
);
    leg_t dec;

    always_comb dec = leg_decide('{hi: req_hi, lo: req_lo}, enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b1;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            if (uv_s)        lock_q <= 1'b1;
            else if (req_lo) lock_q <= 1'b0;
            gate_hi <= dec.hi & ~bs_s & ~lock_q;
            gate_lo <= dec.lo;
        end
    end
endmodule

// File: rtl/tri_gate_guard.sv
module tri_gate_guard #(
    parameter int PHASES    = 3,
    parameter int FILT_CYC  = 100,
    parameter int BLANK_CYC = 35,
    parameter int HOLD_CYC  = 165000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] pwm_hi,
    input  logic [PHASES-1:0] pwm_lo,
    input  logic              drv_enable,
    input  logic              oc_cmp,
    input  logic              vdd_uv,
    input  logic [PHASES-1:0] boot_uv,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo,
    output logic              fault
);
    localparam int SW = 3 * PHASES + 3;

    logic [SW-1:0]       sync_q;
    logic [PHASES-1:0]   hi_s, lo_s, bs_s, hi_f, lo_f, lock_q;
    logic                run_s, oc_s, uv_s, kill;

    gg_sync #(.W(SW)) u_sync (
        .clk(clk), .rst(rst),
        .d({boot_uv, pwm_lo, pwm_hi, vdd_uv, oc_cmp, drv_enable}),
        .q(sync_q)
    );

    assign {bs_s, lo_s, hi_s, uv_s, oc_s, run_s} = sync_q;

    gg_glitch_filter #(.W(2 * PHASES), .FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst(rst),
        .d({lo_s, hi_s}),
        .q({lo_f, hi_f})
    );

    gg_trip_ctrl #(.BLANK_CYC(BLANK_CYC), .HOLD_CYC(HOLD_CYC)) u_trip (
        .clk(clk), .rst(rst),
        .oc_s(oc_s), .uv_s(uv_s),
        .kill(kill), .fault(fault)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        gg_phase_leg u_leg (
            .clk(clk), .rst(rst),
            .req_hi(hi_f[p]), .req_lo(lo_f[p]),
            .enable(run_s & ~kill),
            .uv_s(uv_s), .bs_s(bs_s[p]),
            .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p]),
            .lock_q(lock_q[p])
        );
    end
endmodule

// File: rtl/gg_guard_checker.sv
module gg_guard_checker #(
    parameter int PHASES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo,
    input logic              fault,
    input logic [PHASES-1:0] bs_s,
    input logic [PHASES-1:0] lock_q
);
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0);  // R2

    AST_FAULT_KILLS_ALL: assert property (@(posedge clk) disable iff (rst)
        fault |=> (gate_hi == '0 && gate_lo == '0));  // R4

    AST_BOOT_UV_HI_OFF: assert property (@(posedge clk) disable iff (rst)
        (bs_s != '0) |=> ((gate_hi & $past(bs_s)) == '0));  // R6

    AST_LOCKOUT_HI_OFF: assert property (@(posedge clk) disable iff (rst)
        (lock_q != '0) |=> ((gate_hi & $past(lock_q)) == '0));  // R7
endmodule

bind tri_gate_guard gg_guard_checker #(.PHASES(PHASES)) u_chk (
    .clk(clk), .rst(rst),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault),
    .bs_s(bs_s), .lock_q(lock_q)
);

// File: tb/tri_gate_guard_bench.sv
module tri_gate_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FILT  = 3;
    localparam int BLANK = 4;
    localparam int HOLD  = 20;
    localparam int SETTLE = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pwm_hi = '0, pwm_lo = '0, boot_uv = '0;
    logic       drv_enable = 1'b0, oc_cmp = 1'b0, vdd_uv = 1'b0;
    logic [2:0] gate_hi, gate_lo;
    logic       fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tri_gate_guard #(.FILT_CYC(FILT), .BLANK_CYC(BLANK), .HOLD_CYC(HOLD)) u_tri_gate_guard (
        .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .drv_enable(drv_enable), .oc_cmp(oc_cmp), .vdd_uv(vdd_uv), .boot_uv(boot_uv),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
    );

    // Vector fields: [12:10] hi req, [9:7] lo req, [6] enable, [5:3] gate_hi, [2:0] gate_lo
    localparam logic [12:0] VEC [8] = '{
        {3'b001, 3'b000, 1'b1, 3'b001, 3'b000},  // R1
        {3'b000, 3'b111, 1'b1, 3'b000, 3'b111},  // R1
        {3'b101, 3'b010, 1'b1, 3'b101, 3'b010},  // R1
        {3'b111, 3'b111, 1'b1, 3'b000, 3'b000},  // R2
        {3'b011, 3'b110, 1'b1, 3'b001, 3'b100},  // R2
        {3'b101, 3'b010, 1'b0, 3'b000, 3'b000},  // R3
        {3'b000, 3'b000, 1'b1, 3'b000, 3'b000},  // R1
        {3'b110, 3'b001, 1'b1, 3'b110, 3'b001}   // R3 resume
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic unlock_all();
        pwm_hi = '0; pwm_lo = 3'b111; step(SETTLE);
        pwm_lo = '0; step(SETTLE);
    endtask

    initial begin
        step(3);
        check("R10 reset gates", {gate_hi, gate_lo}, 6'b0);
        check("R10 reset fault", fault, 1'b0);
        rst = 1'b0;
        step(1);
        check("R10 after reset", {fault, gate_hi, gate_lo}, 7'b0);

        // R7: lockout armed out of reset
        drv_enable = 1'b1; pwm_hi = 3'b111; step(SETTLE);
        check("R7 locked after reset", gate_hi, 3'b000);
        unlock_all();
        pwm_hi = 3'b111; step(SETTLE);
        check("R7 released after low seen", gate_hi, 3'b111);

        // Logic table
        for (int i = 0; i < 8; i++) begin
            pwm_hi = VEC[i][12:10]; pwm_lo = VEC[i][9:7]; drv_enable = VEC[i][6];
            step(SETTLE);
            check($sformatf("R1/R2/R3 vector %0d", i), {gate_hi, gate_lo}, {VEC[i][5:3], VEC[i][2:0]});
        end

        // R9: short pulses filtered, both polarities
        pwm_hi = 3'b001; pwm_lo = 3'b000; step(SETTLE);
        pwm_lo[0] = 1'b1; step(FILT - 1); pwm_lo[0] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            check("R9 short high pulse", {gate_hi, gate_lo}, 6'b001_000);
            step(1);
        end
        pwm_hi[0] = 1'b0; step(FILT - 1); pwm_hi[0] = 1'b1;
        for (int k = 0; k < 8; k++) begin
            check("R9 short low pulse", gate_hi, 3'b001);
            step(1);
        end

        // R6: bootstrap UV on phase 1 only
        pwm_hi = 3'b011; pwm_lo = 3'b100; step(SETTLE);
        check("R6 baseline", {gate_hi, gate_lo}, 6'b011_100);
        boot_uv = 3'b010; step(6);
        check("R6 only affected high side off", {gate_hi, gate_lo}, 6'b001_100);
        boot_uv = 3'b000; step(6);
        check("R6 resumes", {gate_hi, gate_lo}, 6'b011_100);

        // R4: short over-current pulse ignored
        oc_cmp = 1'b1; step(BLANK - 2); oc_cmp = 1'b0;
        for (int k = 0; k < 8; k++) begin
            check("R4 short trip ignored", {fault, gate_hi, gate_lo}, 7'b0_011_100);
            step(1);
        end

        // R4/R8: qualified trip and hold
        oc_cmp = 1'b1; step(BLANK + 4);
        check("R4 trip fault", fault, 1'b1);
        check("R4 trip gates off", {gate_hi, gate_lo}, 6'b0);
        oc_cmp = 1'b0;
        step(HOLD - 1);
        check("R8 fault held", fault, 1'b1);
        check("R8 gates held off", {gate_hi, gate_lo}, 6'b0);
        step(7);
        check("R8 fault released", fault, 1'b0);
        step(2);
        check("R8 auto resume", {gate_hi, gate_lo}, 6'b011_100);

        // R5/R7: supply undervoltage
        pwm_hi = 3'b111; pwm_lo = 3'b000; step(SETTLE);
        check("R5 baseline", gate_hi, 3'b111);
        vdd_uv = 1'b1; step(6);
        check("R5 uv fault", fault, 1'b1);
        check("R5 uv gates off", {gate_hi, gate_lo}, 6'b0);
        vdd_uv = 1'b0; step(SETTLE);
        check("R5 fault clears", fault, 1'b0);
        check("R7 relocked after uv", gate_hi, 3'b000);
        unlock_all();
        pwm_hi = 3'b111; step(SETTLE);
        check("R7 released after uv", gate_hi, 3'b111);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule